// File: doc/BRIEF.md
# USB Control Endpoint Status Register

This block is the processor-facing control and status register for endpoint 0, the USB control endpoint. It sits between a simple CPU register bus and the serial interface engine (SIE). The processor reads the register to learn where the current control transfer stands. It writes the register to hand packets over, to request a stall, and to acknowledge events. The SIE reports what happened on the wire through one-cycle event pulses.

Two bits of the register are commands and always read back as zero. Writing one to either of them clears one of the SIE-owned flags. An early SETUP that cuts off a transfer in progress raises the transfer-aborted flag. That flag triggers a FIFO flush and blocks processor FIFO access until it is acknowledged. Every qualifying event also produces a one-cycle interrupt request pulse.

The register sits at bus address `CSR_ADDR` (default F1h). Bit layout, MSB first:

| Bit | Meaning |
|---|---|
| 7 | Acknowledge the abort flag (command) |
| 6 | Acknowledge the received-data flag (command) |
| 5 | Stall request |
| 4 | Abort flag |
| 3 | Last-data mark |
| 2 | Stall-done flag |
| 1 | Transmit-ready flag |
| 0 | Received-data flag |

Top module: `usb_ep0_csr`

## Requirements
- R1: After reset, all six flags are 0, `irq` and `fifo_flush` are 0, `stall_req` is 0 and `fifo_access_ok` is 1.
- R2: While `bus_addr` equals `CSR_ADDR`, `bus_rdata` shows the flags at bits 5..0 in the layout above, with bits 7 and 6 always 0. At any other address `bus_rdata` is 0.
- R3: A pulse on `sie_early_end` sets the abort flag (bit 4). Writing 1 to bit 7 clears it. Writing bit 4 directly has no effect.
- R4: On the edge that samples `sie_early_end`, `irq` and `fifo_flush` rise for exactly one cycle and the last-data mark (bit 3) clears. `fifo_access_ok` stays low for as long as the abort flag is set.
- R5: Writing 1 to bit 5 sets the stall request, which drives `stall_req`. A `sie_stall_sent` pulse clears it. Writing 0 to bit 5 has no effect.
- R6: A `sie_stall_sent` or `sie_proto_stall` pulse sets the stall-done flag (bit 2) and pulses `irq`. Writing 0 to bit 2 clears the flag. Writing 1 to bit 2 does not set it.
- R7: Writing 1 to bit 1 sets the transmit-ready flag, and writing 0 has no effect. A `sie_in_sent` pulse clears the flag and pulses `irq`, but only when the flag was set.
- R8: A `sie_rx_valid` pulse sets the received-data flag (bit 0) and pulses `irq`. Writing 1 to bit 6 clears it. Writing bit 0 has no effect.
- R9: Writing 1 to bit 3 sets the last-data mark, and writing 0 has no effect. A `sie_status_done` pulse clears it.
- R10: When an SIE set event and a processor clear command hit the same flag in the same cycle, the flag ends up set.
- R11: A write of 60h sets the stall request, clears the received-data flag and clears the stall-done flag in a single cycle.
- R12: A write to any address other than `CSR_ADDR` changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational from address) |
| sie_rx_valid | input | 1 | Valid OUT/SETUP data received |
| sie_early_end | input | 1 | Control transfer ended without the last-data mark |
| sie_stall_sent | input | 1 | Requested STALL handshake sent |
| sie_proto_stall | input | 1 | STALL sent on a protocol violation |
| sie_in_sent | input | 1 | IN packet delivered to host |
| sie_status_done | input | 1 | Status stage completed |
| irq | output | 1 | One-cycle interrupt request |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| fifo_access_ok | output | 1 | Processor may access the FIFO |
| stall_req | output | 1 | Answer the next transaction with STALL |

## Verification
Every flag, `stall_req` and `fifo_access_ok` changes on the same edge that samples the write or event. `irq` and `fifo_flush` are registered, so they are also high in the cycle right after that edge, and they drop one edge later. `bus_rdata` is combinational from the address. The bench drives inputs 2 ns after a rising edge, lets exactly one edge pass, and then samples. Each result is therefore checked in the first cycle it is due, and each pulse's fall is checked one edge after its rise. All 256 write values are swept from an all-clear state and from an all-set state, with the expected register value computed bit by bit from the write value.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
    // bit positions inside the register, fixed by the software view
    localparam int unsigned BIT_ACK_ABORT   = 7;
    localparam int unsigned BIT_ACK_RX      = 6;
    localparam int unsigned BIT_STALL_REQ   = 5;
    localparam int unsigned BIT_ABORT       = 4;
    localparam int unsigned BIT_LAST_DATA   = 3;
    localparam int unsigned BIT_STALL_DONE  = 2;
    localparam int unsigned BIT_TX_READY    = 1;
    localparam int unsigned BIT_RX_READY    = 0;

    // decoded processor commands, already qualified by the write strobe
    typedef struct packed {
        logic ack_abort;
        logic ack_rx;
        logic set_stall_req;
        logic set_last_data;
        logic clr_stall_done;
        logic set_tx_ready;
    } cmd_t;

    // SIE event pulses
    typedef struct packed {
        logic rx_valid;
        logic early_end;
        logic stall_sent;
        logic proto_stall;
        logic in_sent;
        logic status_done;
    } sie_ev_t;

    // field order matches register bits 5..0
    typedef struct packed {
        logic stall_req;
        logic abort;
        logic last_data;
        logic stall_done;
        logic tx_ready;
        logic rx_ready;
    } flags_t;

    localparam int unsigned FLAG_W = $bits(flags_t);

    typedef struct packed {
        logic irq;
        logic flush;
    } pulse_t;
endpackage

// File: rtl/ep0_cmd_decode.sv
module ep0_cmd_decode
    import ep0_csr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 'hF1
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              sel,
    output cmd_t              cmd
);
    logic wr;

    always_comb begin
        sel = (bus_addr == CSR_ADDR);
        wr  = sel && bus_we;
        cmd.ack_abort      = wr &&  bus_wdata[BIT_ACK_ABORT];
        cmd.ack_rx         = wr &&  bus_wdata[BIT_ACK_RX];
        cmd.set_stall_req  = wr &&  bus_wdata[BIT_STALL_REQ];
        cmd.set_last_data  = wr &&  bus_wdata[BIT_LAST_DATA];
        cmd.clr_stall_done = wr && !bus_wdata[BIT_STALL_DONE];
        cmd.set_tx_ready   = wr &&  bus_wdata[BIT_TX_READY];
    end
endmodule

// File: rtl/ep0_flag_core.sv
module ep0_flag_core
    import ep0_csr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cmd_t    cmd,
    input  sie_ev_t ev,
    output flags_t  flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;

        // received data: SIE set beats processor acknowledge
        if (ev.rx_valid)        flags_d.rx_ready = 1'b1;
        else if (cmd.ack_rx)    flags_d.rx_ready = 1'b0;

        // transfer aborted: SIE set beats processor acknowledge
        if (ev.early_end)         flags_d.abort = 1'b1;
        else if (cmd.ack_abort)   flags_d.abort = 1'b0;

        // stall request: a fresh request is kept over a completion
        if (cmd.set_stall_req)    flags_d.stall_req = 1'b1;
        else if (ev.stall_sent)   flags_d.stall_req = 1'b0;

        // stall handshake done, either cause
        if (ev.stall_sent || ev.proto_stall) flags_d.stall_done = 1'b1;
        else if (cmd.clr_stall_done)         flags_d.stall_done = 1'b0;

        // transmit ready: processor arm is kept over a delivery
        if (cmd.set_tx_ready)   flags_d.tx_ready = 1'b1;
        else if (ev.in_sent)    flags_d.tx_ready = 1'b0;

        // last-data mark: end of transfer or abort wins over a set
        if (ev.status_done || ev.early_end) flags_d.last_data = 1'b0;
        else if (cmd.set_last_data)         flags_d.last_data = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/ep0_event_pulse.sv
module ep0_event_pulse
    import ep0_csr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cmd_t    cmd,
    input  sie_ev_t ev,
    input  flags_t  flags_q,
    output logic    irq,
    output logic    fifo_flush
);
    pulse_t pulse_d, pulse_q;
    logic   tx_done;

    always_comb begin
        // a delivery only counts when it really clears an armed flag
        tx_done = ev.in_sent && flags_q.tx_ready && !cmd.set_tx_ready;
        pulse_d.irq   = ev.rx_valid || ev.early_end || ev.stall_sent
                      || ev.proto_stall || tx_done;
        pulse_d.flush = ev.early_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign irq        = pulse_q.irq;
    assign fifo_flush = pulse_q.flush;
endmodule

// File: rtl/usb_ep0_csr.sv
module usb_ep0_csr
    import ep0_csr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 'hF1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sie_rx_valid,
    input  logic              sie_early_end,
    input  logic              sie_stall_sent,
    input  logic              sie_proto_stall,
    input  logic              sie_in_sent,
    input  logic              sie_status_done,
    output logic              irq,
    output logic              fifo_flush,
    output logic              fifo_access_ok,
    output logic              stall_req
);
    localparam int unsigned PAD_W = DATA_W - FLAG_W;

    logic    sel;
    cmd_t    cmd;
    sie_ev_t ev;
    flags_t  flags_q;

    always_comb begin
        ev.rx_valid    = sie_rx_valid;
        ev.early_end   = sie_early_end;
        ev.stall_sent  = sie_stall_sent;
        ev.proto_stall = sie_proto_stall;
        ev.in_sent     = sie_in_sent;
        ev.status_done = sie_status_done;
    end

    ep0_cmd_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_ADDR(CSR_ADDR)
    ) dec_i (
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .sel(sel), .cmd(cmd)
    );

    ep0_flag_core core_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ev(ev), .flags_q(flags_q)
    );

    ep0_event_pulse pulse_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ev(ev), .flags_q(flags_q),
        .irq(irq), .fifo_flush(fifo_flush)
    );

    // command bits 7:6 have no storage and read as zero
    assign bus_rdata      = sel ? {{PAD_W{1'b0}}, flags_q} : '0;
    assign fifo_access_ok = !flags_q.abort;
    assign stall_req      = flags_q.stall_req;
endmodule

// File: rtl/ep0_csr_checker.sv
module ep0_csr_checker
    import ep0_csr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 'hF1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              sie_rx_valid,
    input logic              sie_early_end,
    input logic              sie_stall_sent,
    input logic              sie_proto_stall,
    input logic              sie_in_sent,
    input logic              irq,
    input logic              fifo_flush,
    input logic              fifo_access_ok,
    input logic              stall_req,
    input logic [FLAG_W-1:0] flags
);
    logic wr;
    assign wr = bus_we && (bus_addr == CSR_ADDR);

    p_abort_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_wdata[BIT_ACK_ABORT] && !sie_early_end) |=> !flags[BIT_ABORT]);

    p_abort_effects_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sie_early_end |=> (irq && fifo_flush && !fifo_access_ok && !flags[BIT_LAST_DATA]));

    p_stall_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_stall_sent && !(wr && bus_wdata[BIT_STALL_REQ])) |=> (!stall_req && flags[BIT_STALL_DONE]));

    p_stall_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_stall_sent || sie_proto_stall) |=> (irq && flags[BIT_STALL_DONE]));

    p_tx_delivered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_in_sent && flags[BIT_TX_READY] && !(wr && bus_wdata[BIT_TX_READY]))
            |=> (irq && !flags[BIT_TX_READY]));

    // R10: the SIE set survives a same-cycle acknowledge
    p_rx_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sie_rx_valid |=> (flags[BIT_RX_READY] && irq));

    p_irq_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(rst_n)) |-> $past(sie_rx_valid || sie_early_end || sie_stall_sent
            || sie_proto_stall || (sie_in_sent && flags[BIT_TX_READY])));
endmodule

bind usb_ep0_csr ep0_csr_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_ADDR(CSR_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .sie_rx_valid(sie_rx_valid),
    .sie_early_end(sie_early_end), .sie_stall_sent(sie_stall_sent),
    .sie_proto_stall(sie_proto_stall), .sie_in_sent(sie_in_sent),
    .irq(irq), .fifo_flush(fifo_flush), .fifo_access_ok(fifo_access_ok),
    .stall_req(stall_req), .flags(flags_q)
);

// File: tb/usb_ep0_csr_tb_top.sv
`timescale 1ns/1ps
module usb_ep0_csr_tb_top;
    localparam logic [7:0] CSR = 8'hF1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = CSR;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic sie_rx_valid = 1'b0, sie_early_end = 1'b0, sie_stall_sent = 1'b0;
    logic sie_proto_stall = 1'b0, sie_in_sent = 1'b0, sie_status_done = 1'b0;
    logic irq, fifo_flush, fifo_access_ok, stall_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    usb_ep0_csr #(.ADDR_W(8), .DATA_W(8), .CSR_ADDR(CSR)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sie_rx_valid(sie_rx_valid), .sie_early_end(sie_early_end),
        .sie_stall_sent(sie_stall_sent), .sie_proto_stall(sie_proto_stall),
        .sie_in_sent(sie_in_sent), .sie_status_done(sie_status_done),
        .irq(irq), .fifo_flush(fifo_flush), .fifo_access_ok(fifo_access_ok),
        .stall_req(stall_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        bus_we = 1'b0; bus_wdata = '0;
        sie_rx_valid = 1'b0; sie_early_end = 1'b0; sie_stall_sent = 1'b0;
        sie_proto_stall = 1'b0; sie_in_sent = 1'b0; sie_status_done = 1'b0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [7:0] v);
        bus_we = 1'b1; bus_wdata = v;
        tick();
        idle_inputs();
    endtask

    initial begin
        logic [7:0] e;
        do_reset();
        // R1
        chk("R1 reg", bus_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 flush", {7'd0, fifo_flush}, 8'h00);
        chk("R1 access", {7'd0, fifo_access_ok}, 8'h01);
        chk("R1 stall_req", {7'd0, stall_req}, 8'h00);

        // sweep all write values from the all-clear and the all-set state
        for (int v = 0; v < 256; v++) begin
            logic [7:0] w;
            w = v[7:0];
            do_reset();
            wr(w);
            e = {2'b00, w[5], 1'b0, w[3], 1'b0, w[1], 1'b0};
            chk("R2 R3 R5 R6 R7 R8 R9 sweep clear", bus_rdata, e);
            chk("R5 sweep stall_req", {7'd0, stall_req}, {7'd0, w[5]});
            chk("R2 sweep irq quiet", {7'd0, irq}, 8'h00);
            sie_rx_valid = 1'b1; sie_early_end = 1'b1; sie_proto_stall = 1'b1;
            tick();
            idle_inputs();
            wr(8'h2E);
            chk("R2 all set", bus_rdata, 8'h3F);
            wr(w);
            e = {2'b00, 1'b1, ~w[7], 1'b1, w[2], 1'b1, ~w[6]};
            chk("R3 R6 R8 R11 sweep set", bus_rdata, e);
        end

        // R4 abort sequence
        do_reset();
        wr(8'h08);
        sie_early_end = 1'b1;
        tick();
        idle_inputs();
        chk("R4 irq", {7'd0, irq}, 8'h01);
        chk("R4 flush", {7'd0, fifo_flush}, 8'h01);
        chk("R4 access low", {7'd0, fifo_access_ok}, 8'h00);
        chk("R4 reg", bus_rdata, 8'h10);
        tick();
        chk("R4 irq fall", {7'd0, irq}, 8'h00);
        chk("R4 flush fall", {7'd0, fifo_flush}, 8'h00);
        chk("R4 access held", {7'd0, fifo_access_ok}, 8'h00);
        wr(8'h10);
        chk("R3 bit4 write", bus_rdata, 8'h10);
        wr(8'h80);
        chk("R3 ack", bus_rdata, 8'h00);
        chk("R4 access back", {7'd0, fifo_access_ok}, 8'h01);

        // R10 SIE sets beat acknowledges in the same cycle
        do_reset();
        sie_rx_valid = 1'b1; sie_early_end = 1'b1;
        bus_we = 1'b1; bus_wdata = 8'hC0;
        tick();
        idle_inputs();
        chk("R10 rx+abort kept", bus_rdata, 8'h11);
        sie_proto_stall = 1'b1; bus_we = 1'b1; bus_wdata = 8'hC0;
        tick();
        idle_inputs();
        chk("R10 stall_done kept", bus_rdata, 8'h04);

        // R8
        do_reset();
        wr(8'h01);
        chk("R8 bit0 write", bus_rdata, 8'h00);
        sie_rx_valid = 1'b1;
        tick();
        idle_inputs();
        chk("R8 set", bus_rdata, 8'h01);
        chk("R8 irq", {7'd0, irq}, 8'h01);
        wr(8'h44);
        chk("R8 ack", bus_rdata, 8'h00);

        // R5 R6
        do_reset();
        wr(8'h20);
        wr(8'h04);
        chk("R5 write0 kept", {7'd0, stall_req}, 8'h01);
        sie_stall_sent = 1'b1;
        tick();
        idle_inputs();
        chk("R5 cleared", {7'd0, stall_req}, 8'h00);
        chk("R6 set", bus_rdata, 8'h04);
        chk("R6 irq", {7'd0, irq}, 8'h01);
        wr(8'h00);
        chk("R6 clear", bus_rdata, 8'h00);
        sie_proto_stall = 1'b1;
        tick();
        idle_inputs();
        chk("R6 proto", bus_rdata, 8'h04);
        chk("R6 proto irq", {7'd0, irq}, 8'h01);

        // R11
        do_reset();
        sie_rx_valid = 1'b1; sie_proto_stall = 1'b1;
        tick();
        idle_inputs();
        wr(8'h60);
        chk("R11 reg", bus_rdata, 8'h20);
        chk("R11 stall_req", {7'd0, stall_req}, 8'h01);

        // R7
        do_reset();
        wr(8'h02);
        wr(8'h04);
        chk("R7 write0 kept", bus_rdata, 8'h02);
        sie_in_sent = 1'b1;
        tick();
        idle_inputs();
        chk("R7 cleared", bus_rdata, 8'h00);
        chk("R7 irq", {7'd0, irq}, 8'h01);
        sie_in_sent = 1'b1;
        tick();
        idle_inputs();
        chk("R7 no irq when idle", {7'd0, irq}, 8'h00);

        // R9
        do_reset();
        wr(8'h08);
        wr(8'h04);
        chk("R9 write0 kept", bus_rdata, 8'h08);
        sie_status_done = 1'b1;
        tick();
        idle_inputs();
        chk("R9 status done", bus_rdata, 8'h00);

        // R12
        do_reset();
        bus_addr = 8'hF0;
        wr(8'hFF);
        chk("R2 other addr read", bus_rdata, 8'h00);
        bus_addr = CSR;
        #1;
        chk("R12 no change", bus_rdata, 8'h00);
        chk("R12 stall_req", {7'd0, stall_req}, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule